// File: doc/BRIEF.md
# Two-Engine In-Order Stream Dispatcher

The dispatcher takes one ordered series of commands, each labelled with a stream number and with a kind: compute or copy. It starts them on two engines, one per kind, and the two engines may run at the same time. Each kind has its own waiting queue. A command starts when its engine is free and every older command of its own stream has finished. Commands on stream 0 act as a barrier. Such a command waits for every older command on every stream to finish, and every younger command waits for it to finish.

The engines are modelled inside the block. Each one stays busy for the cycle count carried by the command that started it, then pulses a done flag. Because each queue is strictly first-in first-out, a head command that cannot start holds back every younger command of the same kind, whatever stream those commands belong to. An idle flag reports when nothing is queued and nothing is running.

Top module: `stream_dispatch`

## Requirements
- R1: Two commands on the same non-zero stream never run at once. A younger one starts only after every older one on that stream has finished, including older commands of the other kind.
- R2: A compute command and a copy command on different non-zero streams may run at the same time. Each starts one edge after it is accepted if its engine is free and it has no dependency.
- R3: Commands of one kind start in the order they were accepted, and each engine runs at most one command at a time.
- R4: If the head of a kind's queue cannot start, every younger command of that kind waits behind it, even one from an unrelated stream.
- R5: A command on stream 0 starts only after every older command on every stream has finished.
- R6: A command on any stream that is younger than a stream-0 command starts only after that stream-0 command has finished.
- R7: Each kind has a queue of 8 entries. cmd_ready is low exactly when the queue selected by cmd_kind is full, and a command offered while cmd_ready is low is not taken.
- R8: An engine is busy for exactly len cycles, and a len of 0 counts as 1. A command that was waiting on a finishing command, or on that engine, starts len+1 edges after the start of the command it waited on.
- R9: idle is high exactly when both queues are empty and neither engine is busy. Nothing starts while idle stays high and no command is offered.
- R10: After reset, both queues are empty, both engines are free, idle is high and cmd_ready is high.

cmd_kind encoding: 0 selects compute and 1 selects copy. Stream 0 is the barrier stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The queue for cmd_kind has room |
| cmd_kind | input | 1 | 0 compute, 1 copy |
| cmd_stream | input | SIDW | Stream number; 0 is the barrier stream |
| cmd_len | input | LENW | Busy cycle count of the command |
| cmp_start | output | 1 | One-cycle pulse: a compute command has started |
| cmp_stream | output | SIDW | Stream of the compute command that started |
| cmp_busy | output | 1 | Compute engine is running |
| cmp_done | output | 1 | Last busy cycle of the compute command |
| cpy_start | output | 1 | One-cycle pulse: a copy command has started |
| cpy_stream | output | SIDW | Stream of the copy command that started |
| cpy_busy | output | 1 | Copy engine is running |
| cpy_done | output | 1 | Last busy cycle of the copy command |
| idle | output | 1 | Nothing queued and nothing running |

## Verification
A command accepted at edge A appears as a start pulse one edge later if it is free to run. An engine then stays busy for len cycles. A command waiting on it starts len+1 edges after that start, because the completion updates the stream counters at one edge and the dispatch registers at the next. The bench counts edges, samples every output on the falling edge, and timestamps each start pulse with the index of the edge that raised it. It compares those timestamps with values it computes from the accept edges and lengths. A sweep over stream pairs drawn from {0,1,2} and lengths 1 to 4 derives the expected start of the second command arithmetically: dependent when the streams match or either is 0, independent otherwise.

// File: rtl/sdisp_pkg.sv
package sdisp_pkg;
    typedef enum logic {
        KIND_COMPUTE = 1'b0,
        KIND_COPY    = 1'b1
    } kind_e;

    localparam int NUM_ENGINES = 2;
endpackage

// File: rtl/cmd_fifo.sv
module cmd_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr           = step(st_q.wr);
        end
        if (pop) begin
            st_d.rd = step(st_q.rd);
        end
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/busy_engine.sv
module busy_engine #(
    parameter int LENW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [LENW-1:0] len,
    output logic            busy,
    output logic            done
);
    typedef struct packed {
        logic            busy;
        logic [LENW-1:0] cnt;
    } eng_st_t;

    eng_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = (len == '0) ? LENW'(1) : len;
        end else if (st_q.busy) begin
            if (st_q.cnt == LENW'(1)) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.busy && (st_q.cnt == LENW'(1));

    // R3
    start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R8
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/stream_dispatch.sv
module stream_dispatch #(
    parameter int NSTREAM = 4,
    parameter int QDEPTH  = 8,
    parameter int LENW    = 8,
    parameter int TAGW    = 5,
    localparam int SIDW   = (NSTREAM > 1) ? $clog2(NSTREAM) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic            cmd_kind,
    input  logic [SIDW-1:0] cmd_stream,
    input  logic [LENW-1:0] cmd_len,
    output logic            cmp_start,
    output logic [SIDW-1:0] cmp_stream,
    output logic            cmp_busy,
    output logic            cmp_done,
    output logic            cpy_start,
    output logic [SIDW-1:0] cpy_stream,
    output logic            cpy_busy,
    output logic            cpy_done,
    output logic            idle
);
    import sdisp_pkg::*;

    localparam int NE = NUM_ENGINES;

    typedef struct packed {
        logic [SIDW-1:0] sid;
        logic [LENW-1:0] len;
        logic [TAGW-1:0] seq;
        logic [TAGW-1:0] tick;
        logic [TAGW-1:0] epoch;
    } ent_t;

    localparam int EW = $bits(ent_t);

    typedef struct packed {
        logic [TAGW-1:0]               gseq;
        logic [TAGW-1:0]               epoch;
        logic [TAGW-1:0]               dcnt;
        logic [NSTREAM-1:0][TAGW-1:0]  itk;
        logic [NSTREAM-1:0][TAGW-1:0]  dtk;
        logic [NE-1:0][SIDW-1:0]       run_sid;
        logic [NE-1:0][TAGW-1:0]       run_seq;
        logic [NE-1:0]                 run_def;
        logic [NE-1:0]                 start;
        logic [NE-1:0][SIDW-1:0]       start_sid;
    } top_st_t;

    top_st_t st_d, st_q;

    ent_t            new_ent;
    ent_t            head   [NE];
    logic [EW-1:0]   head_w [NE];
    logic [NE-1:0]   q_empty, q_full, q_push, disp, e_busy, e_done;
    logic            accept;

    assign cmd_ready = !q_full[cmd_kind];
    assign accept    = cmd_valid && cmd_ready;

    always_comb begin
        new_ent       = '0;
        new_ent.sid   = cmd_stream;
        new_ent.len   = cmd_len;
        new_ent.seq   = st_q.gseq;
        new_ent.tick  = st_q.itk[cmd_stream];
        new_ent.epoch = st_q.epoch;
    end

    for (genvar k = 0; k < NE; k++) begin : g_lane
        assign q_push[k] = accept && (cmd_kind == k[0]);
        assign head[k]   = ent_t'(head_w[k]);

        cmd_fifo #(.W(EW), .DEPTH(QDEPTH)) u_q (
            .clk(clk), .rst_n(rst_n), .push(q_push[k]), .din(EW'(new_ent)),
            .pop(disp[k]), .dout(head_w[k]), .empty(q_empty[k]), .full(q_full[k])
        );

        busy_engine #(.LENW(LENW)) u_eng (
            .clk(clk), .rst_n(rst_n), .start(disp[k]), .len(head[k].len),
            .busy(e_busy[k]), .done(e_done[k])
        );
    end

    always_comb begin
        logic [TAGW-1:0] my_age;
        logic            older_wait, def_ok, dep_ok;
        int              o;
        st_d  = st_q;
        disp  = '0;

        for (int k = 0; k < NE; k++) begin
            o          = (k == 0) ? 1 : 0;
            my_age     = st_q.gseq - head[k].seq;
            older_wait = (!q_empty[o] && ((st_q.gseq - head[o].seq) > my_age)) ||
                         (e_busy[o] && ((st_q.gseq - st_q.run_seq[o]) > my_age));
            def_ok     = !older_wait;
            dep_ok     = (st_q.dtk[head[k].sid] == head[k].tick) &&
                         (st_q.dcnt == head[k].epoch);
            disp[k]    = !q_empty[k] && !e_busy[k] &&
                         ((head[k].sid == '0) ? def_ok : dep_ok);
            st_d.start[k] = disp[k];
            if (disp[k]) begin
                st_d.run_sid[k]   = head[k].sid;
                st_d.run_seq[k]   = head[k].seq;
                st_d.run_def[k]   = (head[k].sid == '0);
                st_d.start_sid[k] = head[k].sid;
            end
            if (e_done[k]) begin
                st_d.dtk[st_q.run_sid[k]] = st_d.dtk[st_q.run_sid[k]] + 1'b1;
                if (st_q.run_def[k]) st_d.dcnt = st_d.dcnt + 1'b1;
            end
        end

        if (accept) begin
            st_d.gseq            = st_q.gseq + 1'b1;
            st_d.itk[cmd_stream] = st_q.itk[cmd_stream] + 1'b1;
            if (cmd_stream == '0) st_d.epoch = st_q.epoch + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_start  = st_q.start[KIND_COMPUTE];
    assign cmp_stream = st_q.start_sid[KIND_COMPUTE];
    assign cmp_busy   = e_busy[KIND_COMPUTE];
    assign cmp_done   = e_done[KIND_COMPUTE];
    assign cpy_start  = st_q.start[KIND_COPY];
    assign cpy_stream = st_q.start_sid[KIND_COPY];
    assign cpy_busy   = e_busy[KIND_COPY];
    assign cpy_done   = e_done[KIND_COPY];
    assign idle       = (&q_empty) && !(|e_busy);

    // R1
    stream_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_busy[0] && e_busy[1]) |-> (st_q.run_sid[0] != st_q.run_sid[1]));

    // R5
    barrier_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_busy[0] && e_busy[1]) |-> (!st_q.run_def[0] && !st_q.run_def[1]));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !cmd_valid) |=> !(cmp_start || cpy_start));

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_start |-> cmp_busy);
endmodule

// File: tb/sim_stream_dispatch.sv
module sim_stream_dispatch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_kind = 1'b0;
    logic [1:0] cmd_stream = '0;
    logic [7:0] cmd_len = '0;
    logic       cmd_ready, cmp_start, cmp_busy, cmp_done;
    logic       cpy_start, cpy_busy, cpy_done, idle;
    logic [1:0] cmp_stream, cpy_stream;

    int cyc = 0, nchk = 0, nfail = 0;
    int cmp_n = 0, cpy_n = 0, cmp_bcnt = 0;
    int cmp_st [16];
    int cpy_st [16];
    int cmp_sd [16];
    int cpy_sd [16];
    bit finished = 0;

    always #5 clk = ~clk;

    stream_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_stream(cmd_stream), .cmd_len(cmd_len),
        .cmp_start(cmp_start), .cmp_stream(cmp_stream), .cmp_busy(cmp_busy),
        .cmp_done(cmp_done), .cpy_start(cpy_start), .cpy_stream(cpy_stream),
        .cpy_busy(cpy_busy), .cpy_done(cpy_done), .idle(idle)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cmp_start && cmp_n < 16) begin
            cmp_st[cmp_n] = cyc; cmp_sd[cmp_n] = int'(cmp_stream); cmp_n++;
        end
        if (cpy_start && cpy_n < 16) begin
            cpy_st[cpy_n] = cyc; cpy_sd[cpy_n] = int'(cpy_stream); cpy_n++;
        end
        if (cmp_busy) cmp_bcnt++;
    end

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        cmp_n = 0; cpy_n = 0; cmp_bcnt = 0;
    endtask

    task automatic send(input bit k, input int s, input int l, output int acc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = k; cmd_stream = 2'(s); cmd_len = 8'(l);
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1;
        acc = cyc;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!idle);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        finish_run();
    end

    initial begin
        int a0, a1, a2, ex;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 idle", int'(idle), 1);
        check("R10 ready", int'(cmd_ready), 1);
        check("R10 busy", int'(cmp_busy) + int'(cpy_busy), 0);

        // R2 / R8: independent streams overlap
        clear_logs();
        send(1'b0, 1, 10, a0); send(1'b1, 2, 10, a1);
        check("R9 idle low while active", int'(idle), 0);
        wait_idle();
        check("R8 compute start", cmp_st[0], a0 + 1);
        check("R2 copy start", cpy_st[0], a1 + 1);
        check("R2 overlap", int'(cpy_st[0] - cmp_st[0] < 10), 1);
        check("R8 busy length", cmp_bcnt, 10);

        // R1: same stream across kinds
        clear_logs();
        send(1'b0, 1, 6, a0); send(1'b1, 1, 4, a1);
        wait_idle();
        check("R1 copy waits", cpy_st[0], cmp_st[0] + 7);

        // R4: head-of-line blocking
        clear_logs();
        send(1'b0, 1, 8, a0); send(1'b1, 1, 2, a1); send(1'b1, 2, 2, a2);
        wait_idle();
        check("R1 head waits", cpy_st[0], cmp_st[0] + 9);
        check("R4 blocked behind head", cpy_st[1], cpy_st[0] + 3);
        check("R4 stream", cpy_sd[1], 2);

        // R5 / R6: barrier stream
        clear_logs();
        send(1'b0, 1, 5, a0); send(1'b1, 0, 3, a1); send(1'b0, 2, 2, a2);
        wait_idle();
        check("R5 barrier waits", cpy_st[0], cmp_st[0] + 6);
        check("R6 younger waits", cmp_st[1], cpy_st[0] + 4);

        // R3: same kind in order
        clear_logs();
        send(1'b0, 1, 3, a0); send(1'b0, 2, 3, a1);
        wait_idle();
        check("R3 second start", cmp_st[1], cmp_st[0] + 4);
        check("R3 order first", cmp_sd[0], 1);
        check("R3 order second", cmp_sd[1], 2);

        // Sweep: stream pairs and lengths
        for (int sa = 0; sa < 3; sa++)
            for (int sb = 0; sb < 3; sb++)
                for (int la = 1; la <= 4; la++)
                    for (int lb = 1; lb <= 4; lb++) begin
                        clear_logs();
                        send(1'b0, sa, la, a0); send(1'b1, sb, lb, a1);
                        wait_idle();
                        check("R8 sweep compute start", cmp_st[0], a0 + 1);
                        if (sa == sb || sa == 0 || sb == 0) ex = cmp_st[0] + la + 1;
                        else ex = a1 + 1;
                        if (sa == sb) tag = "R1 sweep";
                        else if (sa == 0) tag = "R6 sweep";
                        else if (sb == 0) tag = "R5 sweep";
                        else tag = "R2 sweep";
                        check(tag, cpy_st[0], ex);
                    end

        // R7: back-pressure per kind
        clear_logs();
        send(1'b0, 1, 40, a0);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 8; i++) send(1'b0, 2, 1, a1);
        @(negedge clk);
        cmd_kind = 1'b0; #1;
        check("R7 compute full", int'(cmd_ready), 0);
        cmd_kind = 1'b1; #1;
        check("R7 copy room", int'(cmd_ready), 1);
        wait_idle();
        check("R7 all started", cmp_n, 9);
        check("R9 idle after drain", int'(idle), 1);
        repeat (5) @(negedge clk);
        check("R9 no start while idle", cmp_n + cpy_n, 9);

        finish_run();
    end
endmodule